// File: doc/BRIEF.md
# UART Transmit and Receive Buffer Pair

This block sits between a UART's bus-side register logic and its serial shifter and buffers characters in both directions. The transmit queue stores 8-bit characters written by the bus side until the shifter takes them. The receive queue stores 12-bit entries, each one a received character in the low byte with the shifter's four error flags above it, until the bus side reads them. Each queue reports empty and full. The receive side reports overrun when the shifter delivers a character that finds no room.

A configuration write loads three settings at once: the deep-mode enable, the transmit trigger level and the receive trigger level. With deep mode off, which is the reset state, each queue holds exactly one entry and behaves as a holding register. With deep mode on, each queue holds `DEPTH` entries (16 by default). Each direction raises a level interrupt based on its own fill-level code.

The bus-side push, the shifter-side pop and the bus-side pop are valid/ready streams. A transfer happens on a rising clock edge where both valid and ready are high. While valid is high and ready is low, the source must hold valid high and keep the data stable. `tx_in_ready` is low exactly when the transmit queue is full. `tx_out_valid` and `rx_out_valid` are high exactly when their queue is non-empty, and the head entry is on the data pins. The shifter's receive push has no ready signal, because a serial line cannot be stalled. A push that finds the receive queue full is lost and reported as an overrun.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, deep mode is off, both trigger codes hold the half setting, both queues are empty and not full, `tx_irq` is 1 and `rx_irq` is 0.
- R2: In deep mode, each queue accepts up to `DEPTH` entries and returns them in arrival order. Full is reported at `DEPTH` entries and empty at zero entries.
- R3: A receive entry is presented as `{err[3:0], data[7:0]}`: the error flags are in bits 11:8 and the character is in bits 7:0.
- R4: With deep mode off, each queue holds one entry, and full is reported while that entry is present.
- R5: A receive push that arrives while the receive queue is full is discarded and the stored entries are unchanged. `rx_overrun` is high for exactly the one cycle that follows that push.
- R6: `tx_in_ready` is low while the transmit queue is full, and no write is taken in that state.
- R7: The trigger-level code selects a threshold of `DEPTH*k/8`. Code 0 gives k=1, code 1 gives k=2, code 2 gives k=4, code 3 gives k=6 and code 4 gives k=7. Codes 5 to 7 act as code 2.
- R8: `rx_irq` is high while the receive count is at or above its threshold. `tx_irq` is high while the transmit count is at or below its threshold. With deep mode off, the receive threshold is 1 and the transmit threshold is 0.
- R9: A configuration write that changes the deep-mode enable empties both queues and ignores pushes and pops in that cycle. A write that leaves the enable unchanged keeps the stored entries.
- R10: A push and a pop accepted in the same cycle leave the fill count unchanged.
- R11: A pop request on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the three configuration fields |
| cfg_deep | input | 1 | Deep-mode enable value |
| cfg_tx_lvl | input | 3 | Transmit trigger-level code |
| cfg_rx_lvl | input | 3 | Receive trigger-level code |
| tx_in_valid | input | 1 | Bus-side transmit write valid |
| tx_in_ready | output | 1 | Transmit queue can accept a write |
| tx_in_data | input | 8 | Transmit character |
| tx_out_valid | output | 1 | Transmit head entry available |
| tx_out_ready | input | 1 | Shifter takes the head entry |
| tx_out_data | output | 8 | Transmit head character |
| rx_in_valid | input | 1 | Shifter delivers a received character |
| rx_in_data | input | 8 | Received character |
| rx_in_err | input | 4 | Error flags for the received character |
| rx_out_valid | output | 1 | Receive head entry available |
| rx_out_ready | input | 1 | Bus side takes the head entry |
| rx_out_data | output | 12 | Receive head entry, flags over character |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | One-cycle pulse when a receive character is lost |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_irq | output | 1 | Receive level interrupt |

## Verification
An incorrect fill count shows at the ports on the next clock edge in the full or empty flag, in `tx_in_ready`, or in an interrupt pin whose threshold lies next to the wrong count. A corrupted pointer shows as a wrong head entry as soon as that entry reaches the front of the queue. A flush that is missed or spurious shows in the flags in the cycle after the configuration write. A lost overrun shows when `rx_overrun` is missing one cycle after a push into a full queue, or when a character appears that should have been dropped.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [2:0] {
    LVL_EIGHTH   = 3'd0,
    LVL_QUARTER  = 3'd1,
    LVL_HALF     = 3'd2,
    LVL_3QUARTER = 3'd3,
    LVL_7EIGHTH  = 3'd4
  } fill_lvl_e;

  // R7: numerator over eighths of the queue depth
  function automatic int unsigned lvl_eighths(logic [2:0] code);
    case (code)
      LVL_EIGHTH:   return 1;
      LVL_QUARTER:  return 2;
      LVL_3QUARTER: return 6;
      LVL_7EIGHTH:  return 7;
      default:      return 4;
    endcase
  endfunction
endpackage

// File: rtl/fifo_queue.sv
module fifo_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          drop
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok;

  assign cap     = deep ? DEPTH_C : CW'(1);
  assign empty   = (count == '0);
  assign full    = (count == cap);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= cap);
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty);
  // R10
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !full && !flush) |=> $stable(count));
  // R5
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> ($stable(count) && $stable(head)));
  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push && !flush) |=> empty);
endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter bit FILL_UP = 1'b1,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep,
  input  logic [2:0]    code,
  input  logic [CW-1:0] count,
  output logic          irq
);
  logic [CW-1:0] thr;

  always_comb begin
    if (deep) thr = CW'((DEPTH * lvl_eighths(code)) / 8);
    else      thr = FILL_UP ? CW'(1) : CW'(0);
  end

  generate
    if (FILL_UP) begin : g_rx
      assign irq = (count >= thr);
      // R8
      rx_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !irq);
    end else begin : g_tx
      assign irq = (count <= thr);
      // R8
      tx_zero_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> irq);
    end
  endgenerate
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TXW   = 8,
  parameter int ERRW  = 4,
  localparam int RXW  = TXW + ERRW,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_deep,
  input  logic [2:0]      cfg_tx_lvl,
  input  logic [2:0]      cfg_rx_lvl,
  input  logic            tx_in_valid,
  output logic            tx_in_ready,
  input  logic [TXW-1:0]  tx_in_data,
  output logic            tx_out_valid,
  input  logic            tx_out_ready,
  output logic [TXW-1:0]  tx_out_data,
  input  logic            rx_in_valid,
  input  logic [TXW-1:0]  rx_in_data,
  input  logic [ERRW-1:0] rx_in_err,
  output logic            rx_out_valid,
  input  logic            rx_out_ready,
  output logic [RXW-1:0]  rx_out_data,
  output logic            tx_empty,
  output logic            tx_full,
  output logic            rx_empty,
  output logic            rx_full,
  output logic            rx_overrun,
  output logic            tx_irq,
  output logic            rx_irq
);
  logic          deep_q;
  logic [2:0]    tx_lvl_q, rx_lvl_q;
  logic          flush;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_drop, rx_drop;

  assign flush = cfg_wr && (cfg_deep != deep_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_q     <= 1'b0;
      tx_lvl_q   <= LVL_HALF;
      rx_lvl_q   <= LVL_HALF;
      rx_overrun <= 1'b0;
    end else begin
      if (cfg_wr) begin
        deep_q   <= cfg_deep;
        tx_lvl_q <= cfg_tx_lvl;
        rx_lvl_q <= cfg_rx_lvl;
      end
      rx_overrun <= rx_drop;
    end
  end

  fifo_queue #(.W(TXW), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .deep(deep_q), .flush,
    .push(tx_in_valid), .push_data(tx_in_data), .pop(tx_out_ready),
    .head(tx_out_data), .empty(tx_empty), .full(tx_full),
    .count(tx_cnt), .drop(tx_drop)
  );

  fifo_queue #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .deep(deep_q), .flush,
    .push(rx_in_valid), .push_data({rx_in_err, rx_in_data}), .pop(rx_out_ready),
    .head(rx_out_data), .empty(rx_empty), .full(rx_full),
    .count(rx_cnt), .drop(rx_drop)
  );

  fifo_level_irq #(.DEPTH(DEPTH), .FILL_UP(1'b0)) u_txirq (
    .clk, .rst_n, .deep(deep_q), .code(tx_lvl_q), .count(tx_cnt), .irq(tx_irq)
  );

  fifo_level_irq #(.DEPTH(DEPTH), .FILL_UP(1'b1)) u_rxirq (
    .clk, .rst_n, .deep(deep_q), .code(rx_lvl_q), .count(rx_cnt), .irq(rx_irq)
  );

  assign tx_in_ready  = !tx_full;
  assign tx_out_valid = !tx_empty;
  assign rx_out_valid = !rx_empty;

  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_in_valid && rx_full));
  // R6
  tx_ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_in_ready);
  // R8
  rx_full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_irq);
  // R4
  holding_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!deep_q && !rx_empty) |-> rx_full);
endmodule

// File: tb/sim_uart_fifo_pair.sv
`timescale 1ns/1ps
module sim_uart_fifo_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_deep = 0;
  logic [2:0] cfg_tx_lvl = 3'd2, cfg_rx_lvl = 3'd2;
  logic tx_in_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rx_out_ready = 0;
  logic [7:0] tx_in_data = 0, rx_in_data = 0;
  logic [3:0] rx_in_err = 0;
  logic tx_in_ready, tx_out_valid, rx_out_valid;
  logic [7:0] tx_out_data;
  logic [11:0] rx_out_data;
  logic tx_empty, tx_full, rx_empty, rx_full, rx_overrun, tx_irq, rx_irq;

  always #2.5 clk = ~clk;

  uart_fifo_pair u0 (.*);

  int total = 0, bad = 0;
  logic [7:0]  mtx[$];
  logic [11:0] mrx[$];
  bit men = 0;
  int mtxl = 2, mrxl = 2;
  bit exp_ovr = 0;

  function automatic int thr_of(int code);
    case (code)
      0: return 2; 1: return 4; 3: return 12; 4: return 14;
      default: return 8;
    endcase
  endfunction

  function automatic int cap(); return men ? 16 : 1; endfunction
  function automatic int rx_thr(); return men ? thr_of(mrxl) : 1; endfunction
  function automatic int tx_thr(); return men ? thr_of(mtxl) : 0; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    int ts = mtx.size();
    int rs = mrx.size();
    chk(tx_empty == (ts == 0), "R2", "tx_empty", tx_empty, ts == 0);
    chk(tx_full == (ts == cap()), "R2", "tx_full", tx_full, ts == cap());
    chk(tx_in_ready == (ts != cap()), "R6", "tx_in_ready", tx_in_ready, ts != cap());
    chk(rx_empty == (rs == 0), "R2", "rx_empty", rx_empty, rs == 0);
    chk(rx_full == (rs == cap()), "R2", "rx_full", rx_full, rs == cap());
    chk(tx_out_valid == (ts != 0), "R11", "tx_out_valid", tx_out_valid, ts != 0);
    chk(rx_out_valid == (rs != 0), "R11", "rx_out_valid", rx_out_valid, rs != 0);
    if (ts != 0) chk(tx_out_data == mtx[0], "R2", "tx_out_data", tx_out_data, mtx[0]);
    if (rs != 0) chk(rx_out_data == mrx[0], "R3", "rx_out_data", rx_out_data, mrx[0]);
    chk(rx_overrun == exp_ovr, "R5", "rx_overrun", rx_overrun, exp_ovr);
    chk(tx_irq == (ts <= tx_thr()), "R8", "tx_irq", tx_irq, ts <= tx_thr());
    chk(rx_irq == (rs >= rx_thr()), "R8", "rx_irq", rx_irq, rs >= rx_thr());
  endtask

  task automatic cyc(bit txp, logic [7:0] txd, bit txr, bit rxp, logic [7:0] rxd,
                     logic [3:0] rxe, bit rxr);
    bit tf, rf;
    tx_in_valid = txp; tx_in_data = txd; tx_out_ready = txr;
    rx_in_valid = rxp; rx_in_data = rxd; rx_in_err = rxe; rx_out_ready = rxr;
    tf = (mtx.size() == cap());
    rf = (mrx.size() == cap());
    @(posedge clk);
    if (txr && mtx.size() != 0) void'(mtx.pop_front());
    if (txp && !tf) mtx.push_back(txd);
    if (rxr && mrx.size() != 0) void'(mrx.pop_front());
    if (rxp && !rf) mrx.push_back({rxe, rxd});
    exp_ovr = rxp && rf;
    @(negedge clk);
    tx_in_valid = 0; tx_out_ready = 0; rx_in_valid = 0; rx_out_ready = 0;
    check_all();
  endtask

  task automatic cfg(bit en, int tl, int rl);
    cfg_wr = 1; cfg_deep = en; cfg_tx_lvl = 3'(tl); cfg_rx_lvl = 3'(rl);
    @(posedge clk);
    if (en != men) begin mtx.delete(); mrx.delete(); end
    men = en; mtxl = tl; mrxl = rl; exp_ovr = 0;
    @(negedge clk);
    cfg_wr = 0;
    check_all();
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1", "flags", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk(tx_irq == 1 && rx_irq == 0, "R1", "irqs", {tx_irq, rx_irq}, 2'b10);
    check_all();

    // R4 holding mode: one entry fills each side
    cyc(1, 8'hA5, 0, 1, 8'h3C, 4'h9, 0);
    chk(tx_full && rx_full, "R4", "holding full", {tx_full, rx_full}, 2'b11);
    cyc(1, 8'h11, 0, 0, 0, 0, 0);   // R6 refused write
    chk(tx_out_data == 8'hA5, "R6", "tx head kept", tx_out_data, 8'hA5);
    cyc(0, 0, 0, 1, 8'h77, 4'h1, 0); // R5 overrun in holding mode
    chk(rx_overrun == 1 && rx_out_data == 12'h93C, "R5", "overrun keep", rx_out_data, 12'h93C);
    cyc(0, 0, 1, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);       // R11 pop on empty
    chk(tx_empty && rx_empty, "R11", "empty pop", {tx_empty, rx_empty}, 2'b11);

    // R9 enable change flushes; same enable keeps
    cyc(1, 8'h01, 0, 1, 8'h02, 4'h0, 0);
    cfg(1, 2, 2);
    chk(tx_empty && rx_empty, "R9", "flush on enable", {tx_empty, rx_empty}, 2'b11);

    // R2 fill sixteen in order, R3 flags on top
    for (int i = 0; i < 16; i++) cyc(1, 8'(i * 7), 0, 1, 8'(i), 4'(i), 0);
    chk(tx_full && rx_full && !tx_in_ready, "R2", "deep full", {tx_full, rx_full}, 2'b11);
    cyc(1, 8'hEE, 0, 1, 8'hEE, 4'hF, 0);
    chk(rx_overrun == 1, "R5", "deep overrun", rx_overrun, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(rx_overrun == 0, "R5", "overrun one cycle", rx_overrun, 0);
    cfg(1, 0, 4);                   // R9 same enable: contents kept
    chk(tx_full && rx_full, "R9", "no flush", {tx_full, rx_full}, 2'b11);
    for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, 0, 0, 1);
    chk(tx_empty && rx_empty, "R2", "drained", {tx_empty, rx_empty}, 2'b11);

    // R7 each level code: rx irq rises at the threshold
    for (int c = 0; c < 8; c++) begin
      cfg(1, c, c);
      for (int k = 0; k < thr_of(c) - 1; k++) cyc(0, 0, 0, 1, 8'(k), 0, 0);
      chk(rx_irq == 0, "R7", "below thr", rx_irq, 0);
      // R10 push and pop together keep the count
      cyc(0, 0, 0, 1, 8'h55, 0, 1);
      chk(rx_irq == 0, "R10", "push+pop", rx_irq, 0);
      cyc(0, 0, 0, 1, 8'h66, 0, 0);
      chk(rx_irq == 1, "R7", "at thr", rx_irq, 1);
      cfg(0, c, c);
      cfg(1, c, c);
    end

    // random traffic in both modes
    for (int m = 0; m < 2; m++) begin
      cfg(m == 0, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
      for (int n = 0; n < 1500; n++)
        cyc($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
            $urandom_range(0, 99) < 60, 8'($urandom), 4'($urandom), $urandom_range(0, 99) < 40);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule